// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Vector Selection

This block gathers thirteen active-high interrupt request lines, numbered 1 to 13, and presents one interrupt to the processor. It presents that interrupt as a 3-bit level and an 8-bit vector. Every clock the request lines are copied into a pending register. Pending sources that the mask register does not block take part in a priority scan. The scan compares a 5-bit key taken from each source's own 8-bit control register.

The winning source either asks for an autovector, which is a fixed function of its level, or takes its vector from a register. Source 8 takes the software vector register. Sources 12 and 13 each take their own peripheral vector register. Any other source gets a fixed default. A register port with a single write strobe and combinational read data gives access to the control registers, the mask, the read-only pending register and the three vector registers. The processor's acknowledge cycle is handled elsewhere.

The level and vector outputs are registered. They reflect the pending, mask and control state as it stood one clock earlier. A change on a request line therefore shows up two rising edges after it is driven: one edge to enter the pending register and one edge to reach the outputs. A register write shows up one edge after the write edge.

Top module: `pic_vectored`

## Requirements
- R1: On every clock the pending register loads request lines 1 to 13, and its bit 0 is always 0. It is read at offset 0x3A. A write to 0x3A changes nothing.
- R2: A source takes part in arbitration only while it is pending and its bit in the 16-bit mask register is 0. A 1 in the mask blocks the source.
- R3: Bits [4:0] of a source's control register form its priority key. The active source with the largest key wins. When keys are equal, the lowest-numbered source wins.
- R4: When no source is active, or the winning key is below 4, the level output is 0 and the vector output is 0.
- R5: The level output equals bits [4:2] of the winning source's control register.
- R6: When bit 7 of the winner's control register is 1, the vector is 24 plus the level.
- R7: When bit 7 of the winner's control register is 0, the vector comes from a fixed choice of source. Source 8 takes the software vector register, source 12 takes peripheral vector A, and source 13 takes peripheral vector B. Every other source gets 0x0F.
- R8: After reset the control registers 1 to 13 hold 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C, 0x1C, 0x80, 0x80, 0x80, 0x00 and 0x00. The mask holds 0x3FFE. All three vector registers hold 0x0F. Both outputs are 0.
- R9: The register map is as follows. Control register n sits at offset 0x13+n and takes the low byte of the write data. The mask is at 0x36, the software vector at 0x42, peripheral vector A at 0x44 and peripheral vector B at 0x46. Reads return the stored value zero-extended to 16 bits. An unmapped offset reads 0.
- R10: The outputs are registered. After a register write or a pending update at one rising edge, the outputs change at the next rising edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req | input | 14 | Request lines; bit n is source n, bit 0 ignored |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| irq_level | output | 3 | Presented interrupt level, 0 when idle |
| irq_vector | output | 8 | Presented interrupt vector, 0 when idle |

## Verification
Random control keys, masks, vector registers and request patterns exercise the scan across many mixes of active sources. The random keys often collide, which tests the lowest-number tie rule. Directed cases cover the remaining distinctions one at a time:
- two equal keys, which separates strict from non-strict comparison;
- a key of 3 against a key of 4, which locates the cutoff;
- non-autovectored sources 8, 12, 13 and 9, which separate the four vector choices;
- a masked top-key source, which shows that the mask blocks it;
- a write to the pending offset, which shows that the pending register cannot be written.

A one-edge sample after a request change tells the registered timing apart from a combinational path.

// File: rtl/pic_pkg.sv
// Shared constants and reset-value function for the interrupt controller.
// Assumes at most 15 sources so that the pending vector fits 16 bits.
package pic_pkg;
    localparam int KEY_W  = 5;
    localparam int CTRL_W = 8;
    localparam int VEC_W  = 8;
    localparam int LVL_W  = 3;

    // Reset value of control register n, computed rather than tabulated.
    function automatic logic [CTRL_W-1:0] ctrl_reset(input int n);
        if (n <= 7)       return CTRL_W'(n * 4);
        else if (n == 8)  return 8'h1C;
        else if (n <= 11) return 8'h80;
        else              return 8'h00;
    endfunction
endpackage

// File: rtl/pic_regs.sv
// Register file of the controller: pending capture, mask, control and
// vector registers, with write decode and combinational read mux.
// Assumes one access per cycle; writes land on the rising edge.
module pic_regs
    import pic_pkg::*;
#(
    parameter int NSRC      = 13,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int CTRL_BASE = 'h14,
    parameter int MASK_ADDR = 'h36,
    parameter int PEND_ADDR = 'h3A,
    parameter int SWV_ADDR  = 'h42,
    parameter int PVA_ADDR  = 'h44,
    parameter int PVB_ADDR  = 'h46,
    parameter logic [DATA_W-1:0] MASK_RST = 16'h3FFE,
    parameter logic [VEC_W-1:0]  VEC_RST  = 8'h0F
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NSRC:0]                irq_req,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    output logic [NSRC:0]                pend_q,
    output logic [DATA_W-1:0]            mask_q,
    output logic [NSRC:1][CTRL_W-1:0]    ctrl_q,
    output logic [VEC_W-1:0]             swv_q,
    output logic [VEC_W-1:0]             pva_q,
    output logic [VEC_W-1:0]             pvb_q
);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_ADDR);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(PEND_ADDR);
    localparam logic [ADDR_W-1:0] A_SWV  = ADDR_W'(SWV_ADDR);
    localparam logic [ADDR_W-1:0] A_PVA  = ADDR_W'(PVA_ADDR);
    localparam logic [ADDR_W-1:0] A_PVB  = ADDR_W'(PVB_ADDR);

    // Capture the request lines each clock; source 0 does not exist.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= {irq_req[NSRC:1], 1'b0};
    end

    // Mask register, full data width.
    always_ff @(posedge clk) begin
        if (!rst_n)                        mask_q <= MASK_RST;
        else if (wr_en && addr == A_MASK)  mask_q <= wdata;
    end

    // Vector registers for the software source and the two peripherals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swv_q <= VEC_RST;
            pva_q <= VEC_RST;
            pvb_q <= VEC_RST;
        end else if (wr_en) begin
            if (addr == A_SWV) swv_q <= wdata[VEC_W-1:0];
            if (addr == A_PVA) pva_q <= wdata[VEC_W-1:0];
            if (addr == A_PVB) pvb_q <= wdata[VEC_W-1:0];
        end
    end

    // One control register per source at consecutive byte offsets.
    for (genvar n = 1; n <= NSRC; n++) begin : g_ctrl
        localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_BASE + n - 1);
        // Hold or load control register n.
        always_ff @(posedge clk) begin
            if (!rst_n)                        ctrl_q[n] <= ctrl_reset(n);
            else if (wr_en && addr == A_CTRL)  ctrl_q[n] <= wdata[CTRL_W-1:0];
        end
    end

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        rdata = '0;
        if (addr == A_MASK) rdata = mask_q;
        if (addr == A_PEND) rdata = DATA_W'(pend_q);
        if (addr == A_SWV)  rdata = DATA_W'(swv_q);
        if (addr == A_PVA)  rdata = DATA_W'(pva_q);
        if (addr == A_PVB)  rdata = DATA_W'(pvb_q);
        for (int n = 1; n <= NSRC; n++) begin
            if (addr == ADDR_W'(CTRL_BASE + n - 1)) rdata = DATA_W'(ctrl_q[n]);
        end
    end

    AST_PEND_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q[0] == 1'b0);  // R1
endmodule

// File: rtl/pic_arbiter.sv
// Combinational priority scan over the active sources.
// Assumes keys are bits [4:0] of each control register; a later source
// replaces the current winner only with a strictly larger key.
module pic_arbiter
    import pic_pkg::*;
#(
    parameter int NSRC    = 13,
    parameter int DATA_W  = 16,
    parameter int MIN_KEY = 4,
    localparam int SRC_W  = $clog2(NSRC + 1)
) (
    input  logic [NSRC:0]             pend,
    input  logic [DATA_W-1:0]         mask,
    input  logic [NSRC:1][CTRL_W-1:0] ctrl,
    output logic                      win_valid,
    output logic [SRC_W-1:0]          win_src,
    output logic [CTRL_W-1:0]         win_ctrl
);
    logic [NSRC:0]      active;
    logic [KEY_W-1:0]   best_key;

    // Unmasked pending sources.
    assign active = pend & ~mask[NSRC:0];

    // Scan 1..NSRC keeping the first strictly largest key.
    always_comb begin
        best_key = '0;
        win_src  = '0;
        win_ctrl = '0;
        for (int i = 1; i <= NSRC; i++) begin
            if (active[i] && ctrl[i][KEY_W-1:0] > best_key) begin
                best_key = ctrl[i][KEY_W-1:0];
                win_src  = SRC_W'(i);
                win_ctrl = ctrl[i];
            end
        end
        win_valid = (best_key >= KEY_W'(MIN_KEY));
    end
endmodule

// File: rtl/pic_vector.sv
// Chooses the vector for the winning source and registers level and
// vector toward the processor. Assumes level is control bits [4:2] and
// autovector request is control bit 7.
module pic_vector
    import pic_pkg::*;
#(
    parameter int NSRC    = 13,
    parameter int SWV_SRC = 8,
    parameter int PVA_SRC = 12,
    parameter int PVB_SRC = 13,
    parameter int AUTO_BASE = 24,
    parameter logic [VEC_W-1:0] DEF_VEC = 8'h0F,
    localparam int SRC_W  = $clog2(NSRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               win_valid,
    input  logic [SRC_W-1:0]   win_src,
    input  logic [CTRL_W-1:0]  win_ctrl,
    input  logic [VEC_W-1:0]   swv,
    input  logic [VEC_W-1:0]   pva,
    input  logic [VEC_W-1:0]   pvb,
    output logic [LVL_W-1:0]   level_q,
    output logic [VEC_W-1:0]   vector_q
);
    logic [LVL_W-1:0] lvl_d;
    logic [VEC_W-1:0] vec_d;
    logic             auto_req;

    assign auto_req = win_ctrl[7];

    // Next level and vector from the winner.
    always_comb begin
        lvl_d = '0;
        vec_d = '0;
        if (win_valid) begin
            lvl_d = win_ctrl[4:2];
            if (auto_req)                          vec_d = VEC_W'(AUTO_BASE) + VEC_W'(lvl_d);
            else if (win_src == SRC_W'(SWV_SRC))   vec_d = swv;
            else if (win_src == SRC_W'(PVA_SRC))   vec_d = pva;
            else if (win_src == SRC_W'(PVB_SRC))   vec_d = pvb;
            else                                   vec_d = DEF_VEC;
        end
    end

    // Output register toward the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q  <= '0;
            vector_q <= '0;
        end else begin
            level_q  <= lvl_d;
            vector_q <= vec_d;
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        level_q == '0 |-> vector_q == '0);  // R4
    AST_LEVEL_FROM_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(win_valid) |-> level_q == $past(win_ctrl[4:2]));  // R5
    AST_AUTOVEC: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(win_valid && win_ctrl[7])
        |-> vector_q == VEC_W'(AUTO_BASE) + VEC_W'(level_q));  // R6
endmodule

// File: rtl/pic_vectored.sv
// Top of the prioritised interrupt controller: register file, priority
// scan and registered vector output. Assumes request lines are already
// synchronous to clk.
module pic_vectored
    import pic_pkg::*;
#(
    parameter int NSRC   = 13,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    localparam int SRC_W = $clog2(NSRC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC:0]     irq_req,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [LVL_W-1:0]  irq_level,
    output logic [VEC_W-1:0]  irq_vector
);
    logic [NSRC:0]             pend_q;
    logic [DATA_W-1:0]         mask_q;
    logic [NSRC:1][CTRL_W-1:0] ctrl_q;
    logic [VEC_W-1:0]          swv_q, pva_q, pvb_q;
    logic                      win_valid;
    logic [SRC_W-1:0]          win_src;
    logic [CTRL_W-1:0]         win_ctrl;

    pic_regs #(.NSRC(NSRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .wr_en(reg_we), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .pend_q(pend_q), .mask_q(mask_q), .ctrl_q(ctrl_q),
        .swv_q(swv_q), .pva_q(pva_q), .pvb_q(pvb_q)
    );

    pic_arbiter #(.NSRC(NSRC), .DATA_W(DATA_W)) u_arb (
        .pend(pend_q), .mask(mask_q), .ctrl(ctrl_q),
        .win_valid(win_valid), .win_src(win_src), .win_ctrl(win_ctrl)
    );

    pic_vector #(.NSRC(NSRC)) u_vec (
        .clk(clk), .rst_n(rst_n),
        .win_valid(win_valid), .win_src(win_src), .win_ctrl(win_ctrl),
        .swv(swv_q), .pva(pva_q), .pvb(pvb_q),
        .level_q(irq_level), .vector_q(irq_vector)
    );

    AST_PEND_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pend_q[NSRC:1] == $past(irq_req[NSRC:1]));  // R1
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past((pend_q & ~mask_q[NSRC:0]) == '0)
        |-> irq_level == '0 && irq_vector == '0);  // R2
    AST_WIN_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> pend_q[win_src] && !mask_q[win_src]);  // R2
endmodule

// File: tb/pic_vectored_test.sv
// Self-checking bench: random register setups and request patterns
// against a bench-side reference model, plus directed corner cases.
module pic_vectored_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] irq_req = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [2:0]  irq_level;
    logic [7:0]  irq_vector;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0]  m_ctrl [1:13];
    logic [15:0] m_mask;
    logic [7:0]  m_sw, m_pa, m_pb;

    always #4 clk = ~clk;

    pic_vectored uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_level(irq_level), .irq_vector(irq_vector)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rst_ctrl(input int n);
        if (n <= 7) return 8'(n * 4);
        if (n == 8) return 8'h1C;
        if (n <= 11) return 8'h80;
        return 8'h00;
    endfunction

    function automatic logic [10:0] model(input logic [13:0] req);
        int bk = 0;
        int bs = 0;
        logic [2:0] lv;
        logic [7:0] vc;
        for (int i = 1; i <= 13; i++)
            if (req[i] && !m_mask[i] && int'(m_ctrl[i][4:0]) > bk) begin
                bk = int'(m_ctrl[i][4:0]);
                bs = i;
            end
        if (bk < 4) return '0;
        lv = m_ctrl[bs][4:2];
        if (m_ctrl[bs][7]) vc = 8'd24 + 8'(lv);
        else if (bs == 8)  vc = m_sw;
        else if (bs == 12) vc = m_pa;
        else if (bs == 13) vc = m_pb;
        else               vc = 8'h0F;
        return {lv, vc};
    endfunction

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        if (a >= 8'h14 && a <= 8'h20) m_ctrl[a - 8'h13] = d[7:0];
        if (a == 8'h36) m_mask = d;
        if (a == 8'h42) m_sw = d[7:0];
        if (a == 8'h44) m_pa = d[7:0];
        if (a == 8'h46) m_pb = d[7:0];
    endtask

    task automatic rd(input string req, input logic [7:0] a, input int exp);
        reg_addr = a;
        #1;
        chk(req, int'(reg_rdata), exp);
    endtask

    // Apply requests, wait for pending and output registers, compare.
    task automatic apply(input string req, input logic [13:0] r);
        logic [10:0] e;
        irq_req = r;
        @(negedge clk); @(negedge clk);
        e = model(r);
        chk({req, " level"},  int'(irq_level),  int'(e[10:8]));
        chk({req, " vector"}, int'(irq_vector), int'(e[7:0]));
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [10:0] e_old;
        void'($urandom(32'd2024));
        for (int i = 1; i <= 13; i++) m_ctrl[i] = rst_ctrl(i);
        m_mask = 16'h3FFE; m_sw = 8'h0F; m_pa = 8'h0F; m_pb = 8'h0F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset values through the register port and outputs
        for (int i = 1; i <= 13; i++) rd("R8 ctrl", 8'(8'h13 + i), int'(rst_ctrl(i)));
        rd("R8 mask", 8'h36, 'h3FFE);
        rd("R8 swvec", 8'h42, 'h0F);
        rd("R8 pvecA", 8'h44, 'h0F);
        rd("R8 pvecB", 8'h46, 'h0F);
        chk("R8 level", int'(irq_level), 0);
        chk("R8 vector", int'(irq_vector), 0);

        // R9 register map and unmapped read
        wr(8'h42, 16'h0055); rd("R9 swvec", 8'h42, 'h55);
        wr(8'h44, 16'h0066); rd("R9 pvecA", 8'h44, 'h66);
        wr(8'h46, 16'h0077); rd("R9 pvecB", 8'h46, 'h77);
        wr(8'h36, 16'h0000); rd("R9 mask", 8'h36, 0);
        rd("R9 unmapped", 8'h50, 0);

        // R1 pending capture, bit 0 dropped, write ignored
        irq_req = 14'h2A5B;
        @(negedge clk);
        rd("R1 pending", 8'h3A, 'h2A5A);
        wr(8'h3A, 16'hFFFF);
        irq_req = 14'h0000;
        rd("R1 pending write ignored", 8'h3A, 'h2A5A);
        @(negedge clk);
        rd("R1 pending cleared", 8'h3A, 0);

        // R3 tie: sources 3 and 5 share key 0x14; 3 must win
        for (int i = 1; i <= 13; i++) wr(8'(8'h13 + i), 16'h0000);
        wr(8'h16, 16'h0014);
        wr(8'h18, 16'h0014);
        apply("R3 tie lowest wins", 14'b00_0000_0010_1000);
        chk("R3 tie vector 0x0F", int'(irq_vector), 'h0F);
        // R3 larger key wins regardless of number
        wr(8'h18, 16'h0015);
        apply("R3 larger key", 14'b00_0000_0010_1000);

        // R4 cutoff: key 3 gives nothing, key 4 gives level 1
        wr(8'h16, 16'h0003); wr(8'h18, 16'h0000);
        apply("R4 key 3 quiet", 14'b00_0000_0000_1000);
        chk("R4 key 3 level", int'(irq_level), 0);
        wr(8'h16, 16'h0004);
        apply("R4 key 4", 14'b00_0000_0000_1000);
        chk("R5 level 1", int'(irq_level), 1);

        // R6 autovector
        wr(8'h16, 16'h009C);
        apply("R6 autovector", 14'b00_0000_0000_1000);
        chk("R6 vector 31", int'(irq_vector), 31);

        // R7 vector sources for non-autovectored winners
        wr(8'h16, 16'h0000);
        wr(8'h1B, 16'h0010); apply("R7 source 8 swvec", 14'h0100);
        chk("R7 swvec value", int'(irq_vector), 'h55);
        wr(8'h1F, 16'h0018); apply("R7 source 12 pvecA", 14'h1000);
        chk("R7 pvecA value", int'(irq_vector), 'h66);
        wr(8'h20, 16'h001C); apply("R7 source 13 pvecB", 14'h2000);
        chk("R7 pvecB value", int'(irq_vector), 'h77);
        wr(8'h1C, 16'h001F); apply("R7 source 9 default", 14'h0200);
        chk("R7 default value", int'(irq_vector), 'h0F);

        // R2 masked top-key source is skipped
        wr(8'h36, 16'h0200);
        apply("R2 masked source 9", 14'h3300);
        wr(8'h36, 16'h3FFE);
        apply("R2 all masked", 14'h3FFE);
        chk("R2 all masked level", int'(irq_level), 0);
        wr(8'h36, 16'h0000);

        // R10 timing: one edge after request change the old output stays
        apply("R10 baseline", 14'h0200);
        e_old = model(14'h0200);
        irq_req = 14'h0000;
        @(negedge clk);
        chk("R10 output held one edge", int'({irq_level, irq_vector}), int'(e_old));
        @(negedge clk);
        chk("R10 output after two edges", int'({irq_level, irq_vector}), 0);
        // R10 write: output changes one edge after the write edge
        irq_req = 14'h0200;
        @(negedge clk); @(negedge clk);
        wr(8'h1C, 16'h0008);
        chk("R10 write not yet seen", int'(irq_level), 7);
        @(negedge clk);
        chk("R10 write seen", int'(irq_level), 2);

        // Random mix: R2 R3 R4 R5 R6 R7
        for (int it = 0; it < 400; it++) begin
            int nw;
            nw = int'($urandom_range(0, 4));
            for (int k = 0; k < nw; k++) begin
                int s;
                logic [7:0] v;
                s = int'($urandom_range(1, 13));
                v = 8'($urandom);
                v[6:5] = 2'b00;
                if ($urandom_range(0, 3) == 0) v[4:0] = 5'h14;
                wr(8'(8'h13 + s), {8'h00, v});
            end
            if ($urandom_range(0, 3) == 0) wr(8'h36, 16'($urandom) & 16'h3FFE);
            if ($urandom_range(0, 7) == 0) wr(8'h42, 16'($urandom_range(0, 255)));
            if ($urandom_range(0, 7) == 0) wr(8'h44, 16'($urandom_range(0, 255)));
            if ($urandom_range(0, 7) == 0) wr(8'h46, 16'($urandom_range(0, 255)));
            apply("R3 random", 14'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule